// File: doc/BRIEF.md
# Floating-point / integer register move unit with condition-field update

This unit carries out the transfer operations between the floating-point register file and the integer register file. It handles four legal operations, chosen by a 3-bit select. Two of them copy all 64 bits unchanged, one in each direction. A third narrows a double-precision value from a floating-point register into a single-precision bit pattern and sends it to an integer register, rounding to nearest-even. The fourth reads a single-precision pattern from the low half of an integer register and widens it exactly to double precision for a floating-point register. The register files sit outside the block. The unit takes the source operand and returns the value to write, with a write enable.

When the record bit is set, the unit also produces a 4-bit condition field and the index of the field to update. A result bound for an integer register is compared against zero as a signed integer, which gives condition field 0. A result bound for a floating-point register gives condition field 1, which is copied from the four floating-point exception-summary bits supplied at an input. Any select value outside the four legal codes is reported as an illegal operation, and nothing is written.

The control is a three-state machine. IDLE means no result is presented. DONE presents a legal result. TRAP presents an illegal-operation report. The transitions are the same from every state: a valid legal operation goes to DONE, a valid illegal operation goes to TRAP, and a cycle with no valid operation goes to IDLE. Reset enters IDLE. Every result appears one clock after the operation is issued.

Top module: `fpmv_xfer_unit`

## Requirements
- R1: Select 3'b000 (raw float-to-integer move) presents the 64-bit source unchanged on res_data with res_wen=1 one cycle after issue.
- R2: Select 3'b001 (raw integer-to-float move) presents the 64-bit source unchanged on res_data with res_wen=1 one cycle after issue.
- R3: Select 3'b010 rounds the source double to single precision with round-to-nearest, ties to even, and places the 32-bit pattern in res_data[31:0] with res_data[63:32]=0.
- R4: Under select 3'b010, a finite value that overflows single precision, either before or after rounding, gives a signed infinity. A NaN gives a quiet NaN: sign kept, exponent all ones, bit 22 set, and bits 21:0 taken from source fraction bits 50:29. A double subnormal gives a signed zero. Results below the single normal range are rounded into single subnormals.
- R5: Select 3'b011 reads src[31:0] as a single-precision value and presents its exact double form, and ignores src[63:32]. Single subnormals are normalised. An infinity or NaN keeps its sign and its 23 fraction bits in result bits 51:29, with the low 29 bits zero.
- R6: With rec_bit=1 and select 3'b000 or 3'b010, cr_wen=1 and cr_idx=0. cr_field is {LT,GT,EQ,SO} in bits 3..0: LT, GT and EQ come from a signed 64-bit compare of the result with zero, and SO equals so_in at issue.
- R7: With rec_bit=1 and select 3'b001 or 3'b011, cr_wen=1, cr_idx=1, and cr_field equals fpscr_sum at issue (bit 3 FX, bit 2 FEX, bit 1 VX, bit 0 OX).
- R8: With rec_bit=0, cr_wen, cr_field and cr_idx are all 0 for the result.
- R9: Selects 3'b100 to 3'b111 give illegal_op=1 and res_valid=1 one cycle after issue, with res_wen=0, cr_wen=0 and res_data=0 even when rec_bit=1.
- R10: In reset, and in the cycle after a cycle with op_valid=0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_sel | input | 3 | Operation select |
| rec_bit | input | 1 | Request a condition-field update |
| src | input | 64 | Source register value |
| so_in | input | 1 | Summary-overflow bit for condition field 0 |
| fpscr_sum | input | 4 | Exception-summary bits {FX,FEX,VX,OX} for condition field 1 |
| res_valid | output | 1 | A result or trap is presented |
| res_wen | output | 1 | Write enable for the destination register |
| res_data | output | 64 | Value to write |
| cr_wen | output | 1 | Condition field write enable |
| cr_field | output | 4 | Condition field value |
| cr_idx | output | 3 | Index of the condition field to write |
| illegal_op | output | 1 | The issued select was not a legal code |

## Verification
Every output belonging to an operation is due exactly one rising edge after the cycle in which the operation is issued, and the outputs after an idle cycle are due at that same edge. The bench applies inputs at a falling edge and computes the expected outputs from those inputs with a behavioural model built on real arithmetic. It then waits for one rising edge and compares every output at the next falling edge, so each clock gets exactly one comparison. The stimulus covers rounding ties, overflow, NaN and subnormal values in both directions, and sequences of back-to-back operations mixed with idle cycles.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;
    localparam int DBL_W     = 64;
    localparam int SGL_W     = 32;
    localparam int DBL_EXP_W = 11;
    localparam int DBL_FRC_W = 52;
    localparam int SGL_EXP_W = 8;
    localparam int SGL_FRC_W = 23;
    localparam int DBL_BIAS  = 1023;
    localparam int SGL_BIAS  = 127;
    localparam int BIAS_GAP  = DBL_BIAS - SGL_BIAS;
    localparam int FRC_DROP  = DBL_FRC_W - SGL_FRC_W;
    localparam int OPS_W     = 3;
    localparam int CRF_W     = 4;
    localparam int CRI_W     = 3;
    localparam int FSUM_W    = 4;

    typedef enum logic [OPS_W-1:0] {
        OP_F2G_RAW = 3'b000,
        OP_G2F_RAW = 3'b001,
        OP_F2G_SGL = 3'b010,
        OP_G2F_SGL = 3'b011
    } mv_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_TRAP = 2'd2
    } mv_state_e;

    localparam logic [CRI_W-1:0] CR_GPR_IDX = 3'd0;
    localparam logic [CRI_W-1:0] CR_FPR_IDX = 3'd1;
endpackage

// File: rtl/fpmv_dbl_to_sgl.sv
module fpmv_dbl_to_sgl
    import fpmv_pkg::*;
(
    input  logic [DBL_W-1:0] dbl,
    output logic [SGL_W-1:0] sgl
);
    localparam int PNT   = 63;
    localparam int EXT_W = DBL_FRC_W + 1 + PNT;
    localparam int SHD_W = PNT + SGL_FRC_W;

    logic                  sgn;
    logic [DBL_EXP_W-1:0]  ex;
    logic [DBL_FRC_W-1:0]  fr;
    logic signed [12:0]    se;
    logic signed [12:0]    sh_full;
    logic [5:0]            sh;
    logic [DBL_FRC_W:0]    full;
    logic [EXT_W-1:0]      ext;
    logic [SHD_W-1:0]      shd;
    logic                  nrm_up;
    logic                  sub_up;
    logic [SGL_W-1:0]      nrm_base;

    always_comb begin
        sgn      = dbl[63];
        ex       = dbl[62:52];
        fr       = dbl[51:0];
        se       = $signed({2'b00, ex}) - 13'(BIAS_GAP);
        full     = {1'b1, fr};
        // right shift that turns the significand into a single subnormal field
        sh_full  = 13'sd30 - se;
        sh       = (sh_full > 13'sd63) ? 6'd63 : sh_full[5:0];
        ext      = {full, {PNT{1'b0}}};
        shd      = SHD_W'(ext >> sh);
        nrm_up   = fr[FRC_DROP-1] & ((|fr[FRC_DROP-2:0]) | fr[FRC_DROP]);
        sub_up   = shd[PNT-1] & ((|shd[PNT-2:0]) | shd[PNT]);
        nrm_base = {sgn, se[7:0], fr[51:29]};

        if (ex == '1) begin
            if (fr != '0) sgl = {sgn, 8'hFF, 1'b1, fr[50:29]};
            else          sgl = {sgn, 8'hFF, 23'd0};
        end else if (ex == '0) begin
            sgl = {sgn, 31'd0};
        end else if (se >= 13'sd255) begin
            sgl = {sgn, 8'hFF, 23'd0};
        end else if (se >= 13'sd1) begin
            sgl = nrm_base + {31'd0, nrm_up};
        end else begin
            sgl = {sgn, 8'd0, shd[SHD_W-1:PNT]} + {31'd0, sub_up};
        end
    end

    // R4: a NaN source never comes out as an infinity
    always_comb begin
        if (ex == '1 && fr != '0) begin
            a_r4_nan_stays_nan: assert (sgl[30:22] == 9'h1FF);
        end
    end
endmodule

// File: rtl/fpmv_sgl_to_dbl.sv
module fpmv_sgl_to_dbl
    import fpmv_pkg::*;
(
    input  logic [SGL_W-1:0] sgl,
    output logic [DBL_W-1:0] dbl
);
    logic                  sgn;
    logic [SGL_EXP_W-1:0]  ex;
    logic [SGL_FRC_W-1:0]  fr;
    logic [4:0]            lead;
    logic [SGL_FRC_W-1:0]  nfr;

    always_comb begin
        sgn  = sgl[31];
        ex   = sgl[30:23];
        fr   = sgl[22:0];
        lead = '0;
        for (int i = 0; i < SGL_FRC_W; i++) begin
            if (fr[i]) lead = 5'(i);
        end
        nfr = SGL_FRC_W'(fr << (5'd23 - lead));

        if (ex == '1) begin
            dbl = {sgn, 11'h7FF, fr, {FRC_DROP{1'b0}}};
        end else if (ex == '0 && fr == '0) begin
            dbl = {sgn, 63'd0};
        end else if (ex == '0) begin
            dbl = {sgn, 11'(BIAS_GAP - SGL_FRC_W + 1) + {6'd0, lead}, nfr, {FRC_DROP{1'b0}}};
        end else begin
            dbl = {sgn, {3'b000, ex} + 11'(BIAS_GAP), fr, {FRC_DROP{1'b0}}};
        end
    end

    // R5: widening never loses the sign
    always_comb begin
        a_r5_sign_kept: assert (dbl[63] == sgl[31]);
    end
endmodule

// File: rtl/fpmv_cond_field.sv
module fpmv_cond_field
    import fpmv_pkg::*;
(
    input  logic [DBL_W-1:0]  res,
    input  logic              to_fpr,
    input  logic              so_in,
    input  logic [FSUM_W-1:0] fpscr_sum,
    output logic [CRF_W-1:0]  field,
    output logic [CRI_W-1:0]  idx
);
    logic lt, gt, eq;

    always_comb begin
        lt = res[DBL_W-1];
        eq = (res == '0);
        gt = !lt && !eq;
        if (to_fpr) begin
            field = fpscr_sum;
            idx   = CR_FPR_IDX;
        end else begin
            field = {lt, gt, eq, so_in};
            idx   = CR_GPR_IDX;
        end
    end
endmodule

// File: rtl/fpmv_xfer_unit.sv
module fpmv_xfer_unit
    import fpmv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPS_W-1:0]  op_sel,
    input  logic              rec_bit,
    input  logic [DBL_W-1:0]  src,
    input  logic              so_in,
    input  logic [FSUM_W-1:0] fpscr_sum,
    output logic              res_valid,
    output logic              res_wen,
    output logic [DBL_W-1:0]  res_data,
    output logic              cr_wen,
    output logic [CRF_W-1:0]  cr_field,
    output logic [CRI_W-1:0]  cr_idx,
    output logic              illegal_op
);
    mv_state_e          state, nxt_state;
    logic               op_legal;
    logic [SGL_W-1:0]   narrow;
    logic [DBL_W-1:0]   widen;
    logic [DBL_W-1:0]   nxt_data;
    logic [CRF_W-1:0]   nxt_cr;
    logic [CRI_W-1:0]   nxt_idx;
    logic [DBL_W-1:0]   pl_data;
    logic [CRF_W-1:0]   pl_cr;
    logic [CRI_W-1:0]   pl_idx;
    logic               pl_rec;

    assign op_legal = (op_sel[OPS_W-1] == 1'b0);

    fpmv_dbl_to_sgl u_narrow (.dbl(src), .sgl(narrow));
    fpmv_sgl_to_dbl u_widen  (.sgl(src[SGL_W-1:0]), .dbl(widen));

    always_comb begin
        unique case (op_sel)
            OP_F2G_SGL: nxt_data = {{(DBL_W-SGL_W){1'b0}}, narrow};
            OP_G2F_SGL: nxt_data = widen;
            default:    nxt_data = src;
        endcase
    end

    fpmv_cond_field u_cond (
        .res       (nxt_data),
        .to_fpr    (op_sel[0]),
        .so_in     (so_in),
        .fpscr_sum (fpscr_sum),
        .field     (nxt_cr),
        .idx       (nxt_idx)
    );

    // next-state: identical departures from every state
    always_comb begin
        nxt_state = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_DONE, ST_TRAP: begin
                if (op_valid) nxt_state = op_legal ? ST_DONE : ST_TRAP;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register with the captured payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pl_data <= '0;
            pl_cr   <= '0;
            pl_idx  <= '0;
            pl_rec  <= 1'b0;
        end else begin
            state <= nxt_state;
            if (op_valid && op_legal) begin
                pl_data <= nxt_data;
                pl_cr   <= nxt_cr;
                pl_idx  <= nxt_idx;
                pl_rec  <= rec_bit;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        res_valid  = 1'b0;
        res_wen    = 1'b0;
        res_data   = '0;
        cr_wen     = 1'b0;
        cr_field   = '0;
        cr_idx     = '0;
        illegal_op = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DONE: begin
                res_valid = 1'b1;
                res_wen   = 1'b1;
                res_data  = pl_data;
                cr_wen    = pl_rec;
                if (pl_rec) begin
                    cr_field = pl_cr;
                    cr_idx   = pl_idx;
                end
            end
            ST_TRAP: begin
                res_valid  = 1'b1;
                illegal_op = 1'b1;
            end
            default: ;
        endcase
    end

    a_r1_raw_f2g: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_F2G_RAW) |=> (res_wen && res_data == $past(src)));

    a_r2_raw_g2f: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_G2F_RAW) |=> (res_wen && res_data == $past(src)));

    a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_F2G_SGL) |=> (res_data[DBL_W-1:SGL_W] == '0));

    a_r6_cr0_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wen && cr_idx == CR_GPR_IDX) |-> ($countones(cr_field[3:1]) == 1));

    a_r7_cr1_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_legal && rec_bit && op_sel[0]) |=> (cr_idx == CR_FPR_IDX && cr_field == $past(fpscr_sum)));

    a_r8_no_record: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !rec_bit) |=> !cr_wen);

    a_r9_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (!res_wen && !cr_wen && res_data == '0));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !res_wen && !cr_wen && !illegal_op));
endmodule

// File: tb/sim_fpmv_xfer_unit.sv
`timescale 1ns/1ps
module sim_fpmv_xfer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        rec_bit = 1'b0;
    logic [63:0] src = '0;
    logic        so_in = 1'b0;
    logic [3:0]  fpscr_sum = '0;
    logic        res_valid, res_wen, cr_wen, illegal_op;
    logic [63:0] res_data;
    logic [3:0]  cr_field;
    logic [2:0]  cr_idx;

    int n_cmp = 0;
    int n_bad = 0;

    logic        e_valid, e_wen, e_crw, e_ill;
    logic [63:0] e_data;
    logic [3:0]  e_field;
    logic [2:0]  e_idx;

    always #5 clk = ~clk;

    fpmv_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .rec_bit(rec_bit), .src(src), .so_in(so_in), .fpscr_sum(fpscr_sum),
        .res_valid(res_valid), .res_wen(res_wen), .res_data(res_data),
        .cr_wen(cr_wen), .cr_field(cr_field), .cr_idx(cr_idx), .illegal_op(illegal_op)
    );

    function automatic real pow2(input int k);
        return 2.0 ** k;
    endfunction

    function automatic logic [31:0] ref_narrow(input logic [63:0] b);
        real a, x, ip, fr;
        int  k, ksc;
        longint q;
        logic [31:0] s;
        s = {b[63], 31'd0};
        if (b[62:52] == 11'h7FF) begin
            if (b[51:0] != 0) return s | 32'h7FC00000 | {10'd0, b[50:29]};
            return s | 32'h7F800000;
        end
        a = $bitstoreal({1'b0, b[62:0]});
        if (a == 0.0) return s;
        k = 0;
        while (a >= pow2(k + 1)) k++;
        while (a < pow2(k)) k--;
        ksc = (k < -126) ? -149 : k - 23;
        x  = a / pow2(ksc);
        ip = $floor(x);
        fr = x - ip;
        q  = longint'($rtoi(ip));
        if (fr > 0.5 || (fr == 0.5 && q[0])) q = q + 1;
        if (k < -126) return s | 32'(q);
        if (q == 64'd16777216) begin
            q = 64'd8388608;
            k = k + 1;
        end
        if (k > 127) return s | 32'h7F800000;
        return s | (32'(k + 127) << 23) | 32'(q - 64'd8388608);
    endfunction

    function automatic logic [63:0] ref_widen(input logic [31:0] b);
        real mag;
        logic [63:0] r;
        int m, e;
        m = int'(b[22:0]);
        e = int'(b[30:23]);
        if (e == 255) return {b[31], 11'h7FF, b[22:0], 29'd0};
        if (e == 0) mag = $itor(m) * pow2(-149);
        else        mag = (1.0 + $itor(m) / pow2(23)) * pow2(e - 127);
        r = $realtobits(mag);
        r[63] = b[31];
        return r;
    endfunction

    task automatic model(input logic v, input logic [2:0] op, input logic rec,
                         input logic [63:0] s, input logic so, input logic [3:0] fs);
        logic [63:0] d;
        e_valid = 1'b0; e_wen = 1'b0; e_crw = 1'b0; e_ill = 1'b0;
        e_data = '0; e_field = '0; e_idx = '0;
        if (!v) return;
        e_valid = 1'b1;
        if (op > 3'd3) begin
            e_ill = 1'b1;
            return;
        end
        case (op)
            3'd2:    d = {32'd0, ref_narrow(s)};
            3'd3:    d = ref_widen(s[31:0]);
            default: d = s;
        endcase
        e_wen  = 1'b1;
        e_data = d;
        if (rec) begin
            e_crw = 1'b1;
            if (op == 3'd1 || op == 3'd3) begin
                e_idx   = 3'd1;
                e_field = fs;
            end else begin
                e_idx   = 3'd0;
                e_field = {$signed(d) < 0, $signed(d) > 0, d == 0, so};
            end
        end
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if ({res_valid, res_wen, cr_wen, illegal_op} !== {e_valid, e_wen, e_crw, e_ill} ||
            res_data !== e_data || cr_field !== e_field || cr_idx !== e_idx) begin
            n_bad++;
            $display("FAIL %s: act v=%b w=%b crw=%b ill=%b d=%h f=%h i=%0d exp v=%b w=%b crw=%b ill=%b d=%h f=%h i=%0d",
                     tag, res_valid, res_wen, cr_wen, illegal_op, res_data, cr_field, cr_idx,
                     e_valid, e_wen, e_crw, e_ill, e_data, e_field, e_idx);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic cyc(input logic v, input logic [2:0] op, input logic rec, input logic [63:0] s,
                       input logic so, input logic [3:0] fs, input string tag);
        op_valid = v; op_sel = op; rec_bit = rec; src = s; so_in = so; fpscr_sum = fs;
        model(v, op, rec, s, so, fs);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: act running exp finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] x;
        @(negedge clk);
        @(negedge clk);
        model(1'b0, 3'd0, 1'b0, '0, 1'b0, '0);
        compare("R10 reset");
        @(negedge clk);
        rst_n = 1'b1;

        cyc(1, 3'd0, 0, 64'h400921FB54442D18, 0, 4'h0, "R1 raw f2g");
        cyc(1, 3'd0, 1, 64'hC000000000000000, 1, 4'h0, "R1 R6 negative so");
        cyc(1, 3'd0, 1, 64'h0000000000000000, 0, 4'h0, "R6 zero eq");
        cyc(1, 3'd0, 1, 64'h0000000000000005, 1, 4'hF, "R6 positive gt");
        cyc(1, 3'd1, 0, 64'h123456789ABCDEF0, 0, 4'h0, "R2 raw g2f");
        cyc(1, 3'd1, 1, 64'h8000000000000000, 1, 4'hA, "R2 R7 cr1");
        cyc(0, 3'd0, 1, 64'hFFFFFFFFFFFFFFFF, 1, 4'h5, "R10 idle");
        cyc(1, 3'd2, 0, 64'h3FF0000000000000, 0, 4'h0, "R3 one");
        cyc(1, 3'd2, 1, 64'h400921FB54442D18, 1, 4'h0, "R3 R6 pi");
        cyc(1, 3'd2, 0, 64'h3FF0000010000000, 0, 4'h0, "R3 tie even down");
        cyc(1, 3'd2, 0, 64'h3FF0000030000000, 0, 4'h0, "R3 tie odd up");
        cyc(1, 3'd2, 0, 64'hBFF0000018000000, 0, 4'h0, "R3 above half");
        cyc(1, 3'd2, 0, 64'h7E37E43C8800759C, 0, 4'h0, "R4 overflow");
        cyc(1, 3'd2, 0, 64'h47EFFFFFF0000000, 0, 4'h0, "R4 round to inf");
        cyc(1, 3'd2, 1, 64'h7FF4000000000001, 0, 4'h0, "R4 nan quiet");
        cyc(1, 3'd2, 0, 64'hFFF0000000000000, 0, 4'h0, "R4 neg inf");
        cyc(1, 3'd2, 0, 64'h8000000000000001, 0, 4'h0, "R4 dbl subnormal");
        cyc(1, 3'd2, 0, 64'h3730000000000000, 0, 4'h0, "R4 sgl subnormal");
        cyc(1, 3'd2, 0, 64'h36A8000000000000, 0, 4'h0, "R4 subnormal tie");
        cyc(1, 3'd2, 0, 64'h380FFFFFF0000000, 0, 4'h0, "R4 round into normal");
        cyc(1, 3'd3, 0, 64'hFFFFFFFF3F800000, 0, 4'h0, "R5 one upper ignored");
        cyc(1, 3'd3, 1, 64'h0000000000000001, 0, 4'h3, "R5 R7 min subnormal");
        cyc(1, 3'd3, 0, 64'h00000000807FFFFF, 0, 4'h0, "R5 max subnormal");
        cyc(1, 3'd3, 0, 64'h000000007FA00001, 0, 4'h0, "R5 nan");
        cyc(1, 3'd3, 0, 64'h0000000080000000, 0, 4'h0, "R5 neg zero");
        cyc(1, 3'd3, 0, 64'h00000000FF800000, 0, 4'h0, "R5 neg inf");
        cyc(1, 3'd0, 0, 64'h8000000000000000, 1, 4'hF, "R8 no record");
        cyc(1, 3'd4, 1, 64'h1111111111111111, 1, 4'hF, "R9 trap 4");
        cyc(1, 3'd5, 0, 64'h2222222222222222, 0, 4'h0, "R9 trap 5");
        cyc(1, 3'd6, 1, 64'h3333333333333333, 0, 4'h0, "R9 trap 6");
        cyc(1, 3'd7, 1, 64'h4444444444444444, 1, 4'h1, "R9 trap 7");
        cyc(0, 3'd2, 1, 64'h3FF0000000000000, 0, 4'h0, "R10 idle after trap");

        x = 64'h9E3779B97F4A7C15;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] s;
            x = x ^ (x << 13);
            x = x ^ (x >> 7);
            x = x ^ (x << 17);
            s = x;
            if (x[20:18] == 3'd0) s[62:52] = 11'h7FF;
            if (x[20:18] == 3'd1) s[62:52] = 11'd880 + {6'd0, x[25:21]};
            if (x[20:18] == 3'd2) s[30:23] = 8'd0;
            cyc(x[63] | x[62], x[2:0], x[5], s, x[6], x[10:7], "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 mixed");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule